// File: doc/BRIEF.md
# Synchronous Burst SRAM Frame Buffer Controller

This controller gives internal requesters access to a 32-bit frame buffer made of up to four synchronous burst SRAM chips. A requester offers a read or a write with a word address, a chip-bank index and a byte mask. The request is either a single word or a four-beat burst. The controller then drives the SRAM pins for each beat: a registered word address, an active-low address-load strobe on the first beat, one active-low read select and one active-low write select per chip, active-low byte write enables, and a split data bus (output, input and output enable). Read data comes back on `rd_data` with a one-cycle `rd_valid` pulse for each beat.

A controller FSM has three states. In `ST_IDLE` the bus is quiet. `ST_WRITE` and `ST_READ` each step through the beats of one transfer. The transitions are:
- `ACCEPT_WR` and `ACCEPT_RD` go from idle into a transfer.
- `CHAIN_WR` and `CHAIN_RD` start a new transfer straight from the last beat of the current one, with no idle cycle between them, even when the chip changes.
- `DRAIN` returns from a last beat to idle when no request is waiting.

A request that arrives in the middle of a burst waits until the last beat. The top address pin is shared. A static configuration input decides whether it carries the highest word-address bit or acts as the read select of the fourth chip.

Top module: `sram_buf_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, every read select, write select, byte write enable and the load strobe are 1 (inactive), `sram_dq_oe` is 0 and `rd_valid` is 0.
- R2: A single write accepted in cycle c (req_valid and req_ready both 1) occupies cycle c+1 only. In that cycle the low 17 bits of the word address are on `sram_addr`, `sram_adsc_n` is 0, only `sram_wsel_n[bank]` is 0, `wr_take` and `sram_dq_oe` are 1, and `sram_dq_o` equals `wr_data`. The bus is idle again in c+2.
- R3: A burst (`req_burst`=1) occupies cycles c+1 to c+4. The address steps A, A+1, A+2, A+3, the chip's select stays low on all four beats, and `sram_adsc_n` is 0 on the first beat only.
- R4: For each read beat in cycle n, `rd_valid` is 1 in cycle n+2 and `rd_data` holds the word that the SRAM returned on `sram_dq_i` during cycle n+1. `rd_valid` is 0 in every other cycle.
- R5: `req_be` bit i enables byte lane i (data bits 8i+7 to 8i). On a write beat `sram_bwe_n` is the inverse of the mask. On every other cycle `sram_bwe_n` is all ones, so a masked write leaves the other lanes of the SRAM word unchanged.
- R6: `sram_dq_oe` is 1 only on write beats. It is 0 on every read-address cycle, so the bus is released one cycle before the SRAM returns data.
- R7: A request offered during the last beat of a transfer is accepted there, and its first beat follows in the next cycle. This holds for a write burst followed by a read burst to another chip.
- R8: `req_ready` is 0 on every beat of a burst except the last. A request held during that time starts in the cycle after the last beat.
- R9: With `cfg_top_is_rsel`=0, `sram_top` carries word-address bit 17 on every beat, and a read of bank 3 drives no read select. With `cfg_top_is_rsel`=1, `sram_top` is 0 exactly on read beats to bank 3, and address bit 17 is not driven.
- R10: At most one read or write select (counting `sram_top` in select mode) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_top_is_rsel | input | 1 | 1: `sram_top` is chip 3 read select; 0: it is address bit 17 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_burst | input | 1 | 1 four-beat burst, 0 single word |
| req_bank | input | 2 | Chip index |
| req_addr | input | 18 | Word address |
| req_be | input | 4 | Byte mask, bit i enables lane i |
| wr_data | input | 32 | Write word for the current beat |
| wr_take | output | 1 | The current cycle consumes `wr_data` |
| rd_data | output | 32 | Returned read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| sram_addr | output | 17 | Word address bits 16..0 |
| sram_top | output | 1 | Address bit 17 or chip 3 read select (active low) |
| sram_adsc_n | output | 1 | Address-load strobe, active low |
| sram_rsel_n | output | 3 | Read selects of chips 0..2, active low |
| sram_wsel_n | output | 4 | Write selects of chips 0..3, active low |
| sram_bwe_n | output | 4 | Byte write enables, active low |
| sram_dq_o | output | 32 | Data driven toward the SRAM |
| sram_dq_i | input | 32 | Data returned by the SRAM |
| sram_dq_oe | output | 1 | Data output enable |

## Verification
Every beat appears on the SRAM pins in the cycle after the beat before it, and the first beat comes in the cycle after acceptance. Read data is due two cycles after its address cycle, and a waiting request starts in the cycle after the last beat. Each scenario task drives its request at a fixed sample point and counts cycles from the acceptance cycle. It then compares pins, `req_ready` and `rd_valid` in exactly the cycle each one is due, and checks the neighbouring cycles for the idle value. The SRAM model in the bench returns each read one cycle after its address, so the read latency of the controller is measured against an independent model.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } sbc_state_e;
endpackage

// File: rtl/sbc_fsm.sv
module sbc_fsm
    import sbc_pkg::*;
#(
    parameter int AW    = 18,
    parameter int BEW   = 4,
    parameter int NCHIP = 4,
    parameter int BURST = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_burst,
    input  logic [$clog2(NCHIP)-1:0] req_bank,
    input  logic [AW-1:0]            req_addr,
    input  logic [BEW-1:0]           req_be,
    output logic                     req_ready,
    output logic                     beat_on,
    output logic                     beat_wr,
    output logic                     beat_first,
    output logic                     beat_last,
    output logic [AW-1:0]            cur_addr,
    output logic [$clog2(NCHIP)-1:0] cur_bank,
    output logic [BEW-1:0]           cur_be
);
    localparam int BW = $clog2(NCHIP);
    localparam int CW = (BURST > 1) ? $clog2(BURST) : 1;

    sbc_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, len_q;
    logic [AW-1:0]   addr_q;
    logic [BW-1:0]   bank_q;
    logic [BEW-1:0]  be_q;
    logic            accept;

    // Output decode from registered state only
    always_comb begin
        beat_on    = (state_q != ST_IDLE);
        beat_wr    = (state_q == ST_WRITE);
        beat_first = beat_on && (cnt_q == '0);
        beat_last  = beat_on && (cnt_q == len_q);
        req_ready  = !beat_on || (cnt_q == len_q);
        cur_addr   = addr_q;
        cur_bank   = bank_q;
        cur_be     = be_q;
    end

    assign accept = req_valid && req_ready;

    // Next state: ACCEPT_*, CHAIN_*, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = req_write ? ST_WRITE : ST_READ;
            end
            ST_WRITE, ST_READ: begin
                if (cnt_q == len_q) begin
                    if (req_valid) state_d = req_write ? ST_WRITE : ST_READ;
                    else           state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            addr_q  <= '0;
            bank_q  <= '0;
            be_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= req_addr;
                bank_q <= req_bank;
                be_q   <= req_be;
                cnt_q  <= '0;
                len_q  <= req_burst ? CW'(BURST - 1) : '0;
            end else if (beat_on) begin
                cnt_q  <= cnt_q + 1'b1;
                addr_q <= addr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbc_decode.sv
module sbc_decode #(
    parameter int DW    = 32,
    parameter int AW    = 18,
    parameter int NCHIP = 4
) (
    input  logic                     cfg_top_is_rsel,
    input  logic                     beat_on,
    input  logic                     beat_wr,
    input  logic                     beat_first,
    input  logic [AW-1:0]            cur_addr,
    input  logic [$clog2(NCHIP)-1:0] cur_bank,
    input  logic [DW/8-1:0]          cur_be,
    input  logic [DW-1:0]            wr_data,
    output logic [AW-2:0]            sram_addr,
    output logic                     sram_top,
    output logic                     sram_adsc_n,
    output logic [NCHIP-2:0]         sram_rsel_n,
    output logic [NCHIP-1:0]         sram_wsel_n,
    output logic [DW/8-1:0]          sram_bwe_n,
    output logic [DW-1:0]            sram_dq_o,
    output logic                     sram_dq_oe,
    output logic                     wr_take,
    output logic                     rd_beat
);
    localparam int BW = $clog2(NCHIP);

    logic wr_beat;
    logic rd_last_chip;

    assign wr_beat      = beat_on && beat_wr;
    assign rd_beat      = beat_on && !beat_wr;
    assign rd_last_chip = rd_beat && (cur_bank == BW'(NCHIP - 1));

    for (genvar g = 0; g < NCHIP; g++) begin : g_wsel
        assign sram_wsel_n[g] = !(wr_beat && (cur_bank == BW'(g)));
    end

    for (genvar g = 0; g < NCHIP - 1; g++) begin : g_rsel
        assign sram_rsel_n[g] = !(rd_beat && (cur_bank == BW'(g)));
    end

    assign sram_top    = cfg_top_is_rsel ? !rd_last_chip : cur_addr[AW-1];
    assign sram_addr   = cur_addr[AW-2:0];
    assign sram_adsc_n = !beat_first;
    assign sram_bwe_n  = wr_beat ? ~cur_be : '1;
    assign sram_dq_oe  = wr_beat;
    assign sram_dq_o   = wr_beat ? wr_data : '0;
    assign wr_take     = wr_beat;
endmodule

// File: rtl/sbc_rd_pipe.sv
module sbc_rd_pipe #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_beat,
    input  logic [DW-1:0] sram_dq_i,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            stage_q  <= rd_beat;
            rd_valid <= stage_q;
            if (stage_q) rd_data <= sram_dq_i;
        end
    end
endmodule

// File: rtl/sram_buf_ctrl.sv
module sram_buf_ctrl #(
    parameter int DW    = 32,
    parameter int AW    = 18,
    parameter int NCHIP = 4,
    parameter int BURST = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_top_is_rsel,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_burst,
    input  logic [$clog2(NCHIP)-1:0] req_bank,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW/8-1:0]          req_be,
    input  logic [DW-1:0]            wr_data,
    output logic                     wr_take,
    output logic [DW-1:0]            rd_data,
    output logic                     rd_valid,
    output logic [AW-2:0]            sram_addr,
    output logic                     sram_top,
    output logic                     sram_adsc_n,
    output logic [NCHIP-2:0]         sram_rsel_n,
    output logic [NCHIP-1:0]         sram_wsel_n,
    output logic [DW/8-1:0]          sram_bwe_n,
    output logic [DW-1:0]            sram_dq_o,
    input  logic [DW-1:0]            sram_dq_i,
    output logic                     sram_dq_oe
);
    localparam int BEW = DW / 8;
    localparam int BW  = $clog2(NCHIP);

    logic            beat_on, beat_wr, beat_first, beat_last, rd_beat;
    logic [AW-1:0]   cur_addr;
    logic [BW-1:0]   cur_bank;
    logic [BEW-1:0]  cur_be;

    sbc_fsm #(.AW(AW), .BEW(BEW), .NCHIP(NCHIP), .BURST(BURST)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_burst  (req_burst),
        .req_bank   (req_bank),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_ready  (req_ready),
        .beat_on    (beat_on),
        .beat_wr    (beat_wr),
        .beat_first (beat_first),
        .beat_last  (beat_last),
        .cur_addr   (cur_addr),
        .cur_bank   (cur_bank),
        .cur_be     (cur_be)
    );

    sbc_decode #(.DW(DW), .AW(AW), .NCHIP(NCHIP)) u_decode (
        .cfg_top_is_rsel (cfg_top_is_rsel),
        .beat_on         (beat_on),
        .beat_wr         (beat_wr),
        .beat_first      (beat_first),
        .cur_addr        (cur_addr),
        .cur_bank        (cur_bank),
        .cur_be          (cur_be),
        .wr_data         (wr_data),
        .sram_addr       (sram_addr),
        .sram_top        (sram_top),
        .sram_adsc_n     (sram_adsc_n),
        .sram_rsel_n     (sram_rsel_n),
        .sram_wsel_n     (sram_wsel_n),
        .sram_bwe_n      (sram_bwe_n),
        .sram_dq_o       (sram_dq_o),
        .sram_dq_oe      (sram_dq_oe),
        .wr_take         (wr_take),
        .rd_beat         (rd_beat)
    );

    sbc_rd_pipe #(.DW(DW)) u_rd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_beat   (rd_beat),
        .sram_dq_i (sram_dq_i),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
    parameter int DW    = 32,
    parameter int AW    = 18,
    parameter int NCHIP = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_top_is_rsel,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AW-2:0]    sram_addr,
    input logic             sram_top,
    input logic             sram_adsc_n,
    input logic [NCHIP-2:0] sram_rsel_n,
    input logic [NCHIP-1:0] sram_wsel_n,
    input logic [DW/8-1:0]  sram_bwe_n,
    input logic             sram_dq_oe,
    input logic             rd_valid,
    input logic             rd_beat,
    input logic             beat_on,
    input logic             beat_first,
    input logic             beat_last
);
    // R10: never two chips selected at once
    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~sram_wsel_n, ~sram_rsel_n, cfg_top_is_rsel & ~sram_top}));

    // R6: no drive while any read select is active
    a_r6_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        ((sram_rsel_n != '1) || (cfg_top_is_rsel && !sram_top)) |-> !sram_dq_oe);

    // R4: each read beat yields a valid word two cycles later
    a_r4_valid_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        rd_beat |-> ##2 rd_valid);

    // R4: no valid word without a read beat two cycles before
    a_r4_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_beat, 2));

    // R5: byte enables only accompany a write select
    a_r5_bwe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_bwe_n != '1) |-> (sram_wsel_n != '1));

    // R3: later beats of a burst step the address by one and keep the strobe high
    a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_on && !beat_first) |-> ((sram_addr == (AW-1)'($past(sram_addr) + 1'b1)) && sram_adsc_n));

    // R8: no acceptance before the last beat
    a_r8_ready_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_on && !beat_last) |-> !req_ready);

    // R7: a request on the last beat starts right away
    a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && req_valid) |=> (beat_first && !sram_adsc_n));
endmodule

bind sram_buf_ctrl sbc_chk #(.DW(DW), .AW(AW), .NCHIP(NCHIP)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_top_is_rsel (cfg_top_is_rsel),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .sram_addr       (sram_addr),
    .sram_top        (sram_top),
    .sram_adsc_n     (sram_adsc_n),
    .sram_rsel_n     (sram_rsel_n),
    .sram_wsel_n     (sram_wsel_n),
    .sram_bwe_n      (sram_bwe_n),
    .sram_dq_oe      (sram_dq_oe),
    .rd_valid        (rd_valid),
    .rd_beat         (rd_beat),
    .beat_on         (beat_on),
    .beat_first      (beat_first),
    .beat_last       (beat_last)
);

// File: tb/sram_buf_ctrl_bench.sv
module sram_buf_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_top_is_rsel = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_burst = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] wr_data = '0;
    logic        wr_take;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [16:0] sram_addr;
    logic        sram_top;
    logic        sram_adsc_n;
    logic [2:0]  sram_rsel_n;
    logic [3:0]  sram_wsel_n;
    logic [3:0]  sram_bwe_n;
    logic [31:0] sram_dq_o;
    logic [31:0] sram_dq_i = '0;
    logic        sram_dq_oe;

    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    logic [13:0] seed = '0;
    logic [31:0] mem [4][64];
    logic [31:0] pend = 32'hDEAD_BEEF;

    sram_buf_ctrl u_sram_buf_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_top_is_rsel (cfg_top_is_rsel),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_write       (req_write),
        .req_burst       (req_burst),
        .req_bank        (req_bank),
        .req_addr        (req_addr),
        .req_be          (req_be),
        .wr_data         (wr_data),
        .wr_take         (wr_take),
        .rd_data         (rd_data),
        .rd_valid        (rd_valid),
        .sram_addr       (sram_addr),
        .sram_top        (sram_top),
        .sram_adsc_n     (sram_adsc_n),
        .sram_rsel_n     (sram_rsel_n),
        .sram_wsel_n     (sram_wsel_n),
        .sram_bwe_n      (sram_bwe_n),
        .sram_dq_o       (sram_dq_o),
        .sram_dq_i       (sram_dq_i),
        .sram_dq_oe      (sram_dq_oe)
    );

    initial forever #5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [13:0] s, input logic t, input logic [16:0] a);
        return {s, t, a};
    endfunction

    // SRAM model: data returned one cycle after its address cycle
    initial begin
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 64; a++) mem[k][a] = '0;
        forever begin
            @(negedge clk);
            sram_dq_i = pend;
            pend      = 32'hDEAD_BEEF;
            wr_data   = pat(seed, sram_top, sram_addr);
            #1;
            for (int k = 0; k < 3; k++)
                if (!sram_rsel_n[k]) pend = mem[k][sram_addr[5:0]];
            if (cfg_top_is_rsel && !sram_top) pend = mem[3][sram_addr[5:0]];
            for (int k = 0; k < 4; k++)
                if (!sram_wsel_n[k])
                    for (int b = 0; b < 4; b++)
                        if (!sram_bwe_n[b]) mem[k][sram_addr[5:0]][8*b +: 8] = sram_dq_o[8*b +: 8];
        end
    end

    task automatic cyc();
        @(negedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_req(input logic w, input logic b, input logic [1:0] bank,
                           input logic [17:0] addr, input logic [3:0] be);
        req_valid = 1'b1;
        req_write = w;
        req_burst = b;
        req_bank  = bank;
        req_addr  = addr;
        req_be    = be;
    endtask

    task automatic t_reset();
        cyc();
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 wsel", 32'(sram_wsel_n), 32'hF);
        chk("R1 rsel", 32'(sram_rsel_n), 32'h7);
        chk("R1 adsc", 32'(sram_adsc_n), 32'd1);
        chk("R1 bwe", 32'(sram_bwe_n), 32'hF);
        chk("R1 dq_oe", 32'(sram_dq_oe), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_write_single();
        seed = 14'd1;
        cyc(); put_req(1'b1, 1'b0, 2'd1, 18'h10, 4'b0100);
        cyc(); req_valid = 1'b0;
        chk("R2 addr", 32'(sram_addr), 32'h10);
        chk("R2 adsc", 32'(sram_adsc_n), 32'd0);
        chk("R2 wsel", 32'(sram_wsel_n), 32'hD);
        chk("R2 rsel", 32'(sram_rsel_n), 32'h7);
        chk("R2 wr_take", 32'(wr_take), 32'd1);
        chk("R6 dq_oe on write", 32'(sram_dq_oe), 32'd1);
        chk("R2 dq_o", sram_dq_o, pat(14'd1, 1'b0, 17'h10));
        chk("R5 bwe mask", 32'(sram_bwe_n), 32'hB);
        cyc();
        chk("R2 idle wsel", 32'(sram_wsel_n), 32'hF);
        chk("R2 idle adsc", 32'(sram_adsc_n), 32'd1);
        chk("R6 idle dq_oe", 32'(sram_dq_oe), 32'd0);
        chk("R5 idle bwe", 32'(sram_bwe_n), 32'hF);
    endtask

    task automatic t_write_burst();
        seed = 14'd2;
        cyc(); put_req(1'b1, 1'b1, 2'd2, 18'h20, 4'hF);
        cyc(); req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R3 addr", 32'(sram_addr), 32'(17'h20 + 17'(k)));
            chk("R3 adsc", 32'(sram_adsc_n), (k == 0) ? 32'd0 : 32'd1);
            chk("R3 wsel", 32'(sram_wsel_n), 32'hB);
            chk("R8 ready", 32'(req_ready), (k == 3) ? 32'd1 : 32'd0);
            chk("R3 dq_o", sram_dq_o, pat(14'd2, 1'b0, 17'h20 + 17'(k)));
            cyc();
        end
        chk("R3 idle wsel", 32'(sram_wsel_n), 32'hF);
    endtask

    task automatic t_read_burst();
        cyc(); put_req(1'b0, 1'b1, 2'd2, 18'h20, 4'hF);
        cyc(); req_valid = 1'b0;
        for (int j = 1; j <= 7; j++) begin
            if (j <= 4) begin
                chk("R6 dq_oe on read", 32'(sram_dq_oe), 32'd0);
                chk("R4 rsel", 32'(sram_rsel_n), 32'h3);
                chk("R3 read addr", 32'(sram_addr), 32'(17'h20 + 17'(j - 1)));
            end
            chk("R4 rd_valid", 32'(rd_valid), (j >= 3 && j <= 6) ? 32'd1 : 32'd0);
            if (j >= 3 && j <= 6)
                chk("R4 rd_data", rd_data, pat(14'd2, 1'b0, 17'h20 + 17'(j - 3)));
            if (j < 7) cyc();
        end
    endtask

    task automatic t_read_masked();
        cyc(); put_req(1'b0, 1'b0, 2'd1, 18'h10, 4'hF);
        cyc(); req_valid = 1'b0;
        cyc();
        chk("R4 rd_valid early", 32'(rd_valid), 32'd0);
        cyc();
        chk("R4 rd_valid due", 32'(rd_valid), 32'd1);
        chk("R5 only lane 2 written", rd_data, pat(14'd1, 1'b0, 17'h10) & 32'h00FF_0000);
        cyc();
        chk("R4 rd_valid after", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_back_to_back();
        seed = 14'd6;
        cyc(); put_req(1'b1, 1'b1, 2'd0, 18'h30, 4'hF);
        cyc(); req_valid = 1'b0;
        for (int j = 1; j <= 10; j++) begin
            if (j <= 4) chk("R7 write beat", 32'({sram_dq_oe, sram_wsel_n}), 32'h1E);
            if (j == 4) begin
                chk("R7 ready on last", 32'(req_ready), 32'd1);
                put_req(1'b0, 1'b1, 2'd2, 18'h20, 4'hF);
            end
            if (j == 5) begin
                req_valid = 1'b0;
                chk("R7 adsc", 32'(sram_adsc_n), 32'd0);
                chk("R7 rsel", 32'(sram_rsel_n), 32'h3);
                chk("R7 wsel", 32'(sram_wsel_n), 32'hF);
                chk("R7 dq_oe", 32'(sram_dq_oe), 32'd0);
                chk("R7 addr", 32'(sram_addr), 32'h20);
            end
            if (j >= 7) begin
                chk("R7 rd_valid", 32'(rd_valid), 32'd1);
                chk("R7 rd_data", rd_data, pat(14'd2, 1'b0, 17'h20 + 17'(j - 7)));
            end
            if (j < 10) cyc();
        end
    endtask

    task automatic t_queued();
        seed = 14'd7;
        cyc(); put_req(1'b1, 1'b1, 2'd0, 18'h30, 4'hF);
        cyc(); put_req(1'b0, 1'b0, 2'd0, 18'h32, 4'hF);
        for (int j = 1; j <= 7; j++) begin
            if (j <= 3) chk("R8 ready mid burst", 32'(req_ready), 32'd0);
            if (j == 4) chk("R8 ready last", 32'(req_ready), 32'd1);
            if (j == 5) begin
                req_valid = 1'b0;
                chk("R8 waited rsel", 32'(sram_rsel_n), 32'h6);
                chk("R8 waited addr", 32'(sram_addr), 32'h32);
                chk("R8 waited adsc", 32'(sram_adsc_n), 32'd0);
            end
            if (j == 6) chk("R8 rd_valid early", 32'(rd_valid), 32'd0);
            if (j == 7) begin
                chk("R8 rd_valid", 32'(rd_valid), 32'd1);
                chk("R8 rd_data", rd_data, pat(14'd7, 1'b0, 17'h32));
            end
            if (j < 7) cyc();
        end
    endtask

    task automatic t_top_pin();
        seed = 14'd8;
        cfg_top_is_rsel = 1'b0;
        cyc(); put_req(1'b1, 1'b0, 2'd3, 18'h20005, 4'hF);
        cyc(); req_valid = 1'b0;
        chk("R9 addr mode top bit", 32'(sram_top), 32'd1);
        chk("R9 addr mode wsel", 32'(sram_wsel_n), 32'h7);
        chk("R9 addr mode low addr", 32'(sram_addr), 32'h5);
        cyc(); put_req(1'b0, 1'b0, 2'd3, 18'h20005, 4'hF);
        cyc(); req_valid = 1'b0;
        chk("R9 addr mode no rsel", 32'(sram_rsel_n), 32'h7);
        chk("R9 addr mode top on read", 32'(sram_top), 32'd1);
        cyc(); cyc();
        cfg_top_is_rsel = 1'b1;
        cyc(); put_req(1'b0, 1'b0, 2'd3, 18'h00005, 4'hF);
        cyc(); req_valid = 1'b0;
        chk("R9 sel mode top low", 32'(sram_top), 32'd0);
        chk("R9 sel mode rsel", 32'(sram_rsel_n), 32'h7);
        cyc(); cyc();
        chk("R9 sel mode rd_data", rd_data, pat(14'd8, 1'b1, 17'h5));
        cyc(); put_req(1'b0, 1'b0, 2'd1, 18'h20010, 4'hF);
        cyc(); req_valid = 1'b0;
        chk("R9 sel mode top high", 32'(sram_top), 32'd1);
        chk("R9 sel mode rsel bank1", 32'(sram_rsel_n), 32'h5);
        cyc(); cyc();
        chk("R9 sel mode bank1 data", rd_data, pat(14'd1, 1'b0, 17'h10) & 32'h00FF_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_write_single();
        t_write_burst();
        t_read_burst();
        t_read_masked();
        t_back_to_back();
        t_queued();
        t_top_pin();
        cyc();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule